// File: doc/BRIEF.md
# Flow-Through Zero-Turnaround Synchronous SRAM

This block is a single-port synchronous static memory with a flow-through read path and a bus protocol that needs no idle turnaround cycles. On each rising clock edge it captures the address and control inputs. A read's word is then presented combinationally from that captured state during the following cycle. A write's data and byte selects arrive one active edge after its address. Reads, writes and deselects may follow one another in any order, and data moves on every clock.

A clock enable freezes the whole block. Three chip selects of mixed polarity qualify each new access. A continue input extends the last access as a four-beat burst, in linear or interleaved order. A sleep input blocks all accesses. An asynchronous output enable gates the data-valid output, and that output also drops by itself while write data is on the bus. The bidirectional data bus appears as separate `dq_in`, `dq_out` and `dq_oe` pins. The word is four 9-bit bytes and the depth is set by a parameter.

Top module: `ztsram_flow`

## Requirements
- R1: A load cycle (`burst_cont`=0) that is selected, with `wr_n`=1, starts a read. Through the whole clock period after that edge, `dq_out` carries the stored word at the captured address, and `dq_oe` is 1 whenever `oe_n` is 0.
- R2: A selected load cycle with `wr_n`=0 starts a write. At the next active edge, `dq_in` is sampled together with `bsel_n`. Byte i is bits [9i+8:9i], and it is replaced only when `bsel_n[i]`=0. All other bytes keep their old value.
- R3: Reads and writes may be issued on consecutive active edges in any mix, with no idle cycle. A read loaded on the edge that takes in a write's data returns the newly merged word of that address.
- R4: A load cycle counts as selected only when `cs1_n`=0, `cs2`=1 and `cs3_n`=0. Any other combination starts no access: nothing is written and `dq_oe` stays 0 in the next cycle.
- R5: `dq_oe` is 0 throughout the data cycle of every write, whatever `oe_n` is. `oe_n`=1 forces `dq_oe` to 0 combinationally, within the same cycle.
- R6: At a rising edge with `clk_en`=0, all state holds. `dq_out` and `dq_oe` keep their values, and a pending write is not performed. The pending write takes its data and byte selects at the next edge that has `clk_en`=1.
- R7: A continue cycle (`burst_cont`=1) repeats the previous access type at the next burst address and ignores the chip selects and `wr_n`. With `burst_ilv`=0, the low two address bits step start+k mod 4 for k=1,2,3, then wrap back to the start. The upper address bits never change.
- R8: With `burst_ilv`=1, the low two bits of beat k are the start bits XOR k, with k counting modulo 4.
- R9: At an active edge with `sleep`=1, the block becomes deselected on a load or a continue cycle: no new access starts and `dq_oe` is 0 in the next cycle.
- R10: While `rst_n` is 0, `dq_oe` is 0 and no access is pending.
- R11: A continue cycle that follows a deselected cycle stays deselected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_en | input | 1 | Clock qualifier; 0 freezes the block |
| addr | input | AW | Word address, captured on load cycles |
| burst_cont | input | 1 | 1 continues the current burst, 0 loads a new access |
| wr_n | input | 1 | 0 requests a write on a load cycle |
| bsel_n | input | 4 | Per-byte write selects, active low, sampled with write data |
| cs1_n | input | 1 | Chip select, active low |
| cs2 | input | 1 | Chip select, active high |
| cs3_n | input | 1 | Chip select, active low |
| burst_ilv | input | 1 | Burst order: 0 linear, 1 interleaved |
| sleep | input | 1 | Blocks new accesses and deselects the block |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dq_in | input | 36 | Write data, incoming half of the data bus |
| dq_out | output | 36 | Read data, outgoing half of the data bus |
| dq_oe | output | 1 | Data bus drive enable |

## Verification
Each operation is due at a fixed count of active edges. Read data and `dq_oe` are valid from the edge that captures the address until the next one, so the bench samples them 1 ns after that edge. Write data belongs to the next enabled edge, and the bench drives it there. Stalled edges delay both results by one edge each, without changing them. The bench models the memory together with that one-edge write lag, and the burst address sequence. It checks the data and enable pins in every cycle. The combinational effect of `oe_n` is checked within a single cycle.

// File: rtl/ztsram_pkg.sv
`timescale 1ns/1ps
package ztsram_pkg;

   typedef enum logic {
      ORD_LINEAR     = 1'b0,
      ORD_INTERLEAVE = 1'b1
   } burst_order_e;

   // Low two address bits of burst beat k, relative to start bits b.
   function automatic logic [1:0] burst_low(input logic [1:0] b,
                                            input logic [1:0] k,
                                            input burst_order_e ord);
      if (ord == ORD_INTERLEAVE) return b ^ k;
      return b + k;
   endfunction

endpackage

// File: rtl/ztsram_lane.sv
`timescale 1ns/1ps
module ztsram_lane #(
   parameter int AW = 6,
   parameter int BW = 9
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [BW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [BW-1:0] rdata
);
   localparam int DEPTH = 1 << AW;

   logic [BW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/ztsram_burst.sv
`timescale 1ns/1ps
module ztsram_burst
   import ztsram_pkg::*;
#(
   parameter int AW = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic          load,
   input  logic          sel,
   input  logic          wr,
   input  logic          sleep,
   input  logic          ilv,
   input  logic [AW-1:0] addr,
   output logic          vld,
   output logic          wr_q,
   output logic [AW-1:0] addr_q
);
   logic [1:0]   base_lo;
   logic [1:0]   cnt;
   logic [1:0]   cnt_nx;
   burst_order_e ord;

   assign cnt_nx = cnt + 2'd1;
   assign ord    = ilv ? ORD_INTERLEAVE : ORD_LINEAR;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld     <= 1'b0;
         wr_q    <= 1'b0;
         addr_q  <= '0;
         base_lo <= 2'd0;
         cnt     <= 2'd0;
      end else if (en) begin
         if (load) begin
            vld     <= sel & ~sleep;
            wr_q    <= wr;
            addr_q  <= addr;
            base_lo <= addr[1:0];
            cnt     <= 2'd0;
         end else begin
            vld         <= vld & ~sleep;
            cnt         <= cnt_nx;
            addr_q[1:0] <= burst_low(base_lo, cnt_nx, ord);
         end
      end
   end
endmodule

// File: rtl/ztsram_flow.sv
`timescale 1ns/1ps
module ztsram_flow #(
   parameter int AW    = 6,
   parameter int NBYTE = 4,
   parameter int BW    = 9
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   clk_en,
   input  logic [AW-1:0]          addr,
   input  logic                   burst_cont,
   input  logic                   wr_n,
   input  logic [NBYTE-1:0]       bsel_n,
   input  logic                   cs1_n,
   input  logic                   cs2,
   input  logic                   cs3_n,
   input  logic                   burst_ilv,
   input  logic                   sleep,
   input  logic                   oe_n,
   input  logic [NBYTE*BW-1:0]    dq_in,
   output logic [NBYTE*BW-1:0]    dq_out,
   output logic                   dq_oe
);
   localparam int DW = NBYTE * BW;

   if (AW < 2 || AW > 12) begin : g_bad_aw
      $error("ztsram_flow: AW must lie in 2..12");
   end
   if (NBYTE < 1 || BW < 1) begin : g_bad_word
      $error("ztsram_flow: NBYTE and BW must be positive");
   end

   logic          sel_in;
   logic          acc_vld;
   logic          acc_wr;
   logic [AW-1:0] acc_addr;
   logic          rd_act;
   logic          wr_act;
   logic [DW-1:0] word;

   assign sel_in = ~cs1_n & cs2 & ~cs3_n;

   ztsram_burst #(.AW(AW)) u_burst (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (clk_en),
      .load   (~burst_cont),
      .sel    (sel_in),
      .wr     (~wr_n),
      .sleep  (sleep),
      .ilv    (burst_ilv),
      .addr   (addr),
      .vld    (acc_vld),
      .wr_q   (acc_wr),
      .addr_q (acc_addr)
   );

   assign wr_act = clk_en & acc_vld & acc_wr;
   assign rd_act = acc_vld & ~acc_wr;

   for (genvar i = 0; i < NBYTE; i++) begin : g_lane
      ztsram_lane #(.AW(AW), .BW(BW)) u_lane (
         .clk   (clk),
         .we    (wr_act & ~bsel_n[i]),
         .waddr (acc_addr),
         .wdata (dq_in[i*BW +: BW]),
         .raddr (acc_addr),
         .rdata (word[i*BW +: BW])
      );
   end

   assign dq_out = rd_act ? word : '0;
   assign dq_oe  = rd_act & ~oe_n;
endmodule

// File: rtl/ztsram_chk.sv
`timescale 1ns/1ps
module ztsram_chk #(
   parameter int AW    = 6,
   parameter int NBYTE = 4,
   parameter int BW    = 9
) (
   input logic                clk,
   input logic                rst_n,
   input logic                clk_en,
   input logic                burst_cont,
   input logic                wr_n,
   input logic                cs1_n,
   input logic                cs2,
   input logic                cs3_n,
   input logic                sleep,
   input logic                oe_n,
   input logic [NBYTE*BW-1:0] dq_out,
   input logic                dq_oe
);
   logic cs_ok;
   assign cs_ok = !cs1_n && cs2 && !cs3_n;

   p_rd_oe_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_en && !burst_cont && wr_n && cs_ok && !sleep) |=> (dq_oe == !oe_n));

   p_wr_cycle_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_en && !burst_cont && !wr_n) |=> !dq_oe);

   p_deselect_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_en && !burst_cont && !cs_ok) |=> !dq_oe);

   p_sleep_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_en && sleep) |=> !dq_oe);

   p_stall_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!clk_en) |=> $stable(dq_out));

   p_reset_quiet_r10: assert property (@(posedge clk)
      (!rst_n) |-> !dq_oe);
endmodule

bind ztsram_flow ztsram_chk #(.AW(AW), .NBYTE(NBYTE), .BW(BW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .clk_en     (clk_en),
   .burst_cont (burst_cont),
   .wr_n       (wr_n),
   .cs1_n      (cs1_n),
   .cs2        (cs2),
   .cs3_n      (cs3_n),
   .sleep      (sleep),
   .oe_n       (oe_n),
   .dq_out     (dq_out),
   .dq_oe      (dq_oe)
);

// File: tb/tb_ztsram_flow.sv
`timescale 1ns/1ps
module tb_ztsram_flow;
   localparam int AW = 6;
   localparam int DEPTH = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          clk_en = 1'b1;
   logic [AW-1:0] addr = '0;
   logic          burst_cont = 1'b0;
   logic          wr_n = 1'b1;
   logic [3:0]    bsel_n = 4'hF;
   logic          cs1_n = 1'b1;
   logic          cs2 = 1'b0;
   logic          cs3_n = 1'b1;
   logic          burst_ilv = 1'b0;
   logic          sleep = 1'b0;
   logic          oe_n = 1'b0;
   logic [35:0]   dq_in = '0;
   logic [35:0]   dq_out;
   logic          dq_oe;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // bench model
   logic [35:0]   emem [DEPTH];
   bit            cur_vld = 1'b0;
   bit            cur_wr = 1'b0;
   logic [AW-1:0] cur_addr = '0;
   logic [1:0]    base = 2'd0;
   logic [1:0]    cnt = 2'd0;
   logic [35:0]   pd_data = '0;
   logic [3:0]    pd_mask = 4'hF;

   ztsram_flow #(.AW(AW), .NBYTE(4), .BW(9)) dut (
      .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .addr(addr),
      .burst_cont(burst_cont), .wr_n(wr_n), .bsel_n(bsel_n),
      .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n), .burst_ilv(burst_ilv),
      .sleep(sleep), .oe_n(oe_n), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
   );

   always #2.5 clk = ~clk;

   function automatic logic [35:0] pat(input int a);
      return (36'(a) * 36'h0_1F1E_1D1C) ^ 36'h9_6969_6969;
   endfunction

   task automatic chk(input bit ok, input string tag,
                      input logic [35:0] act, input logic [35:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // One clock: ld=1 loads (w selects write), ld=0 continues a burst.
   // wd/bm are the data and active-low byte selects for this op if it writes.
   task automatic op(input bit ld, input bit w, input int a,
                     input logic [35:0] wd, input logic [3:0] bm,
                     input logic [2:0] cs, input bit slp, input bit en,
                     input string tag);
      bit csok;
      csok = (cs == 3'b010);
      burst_cont = !ld;
      wr_n = !w;
      addr = AW'(a);
      {cs1_n, cs2, cs3_n} = cs;
      sleep = slp;
      clk_en = en;
      if (en) begin
         dq_in = pd_data;
         bsel_n = pd_mask;
      end else begin
         dq_in = ~pd_data;
         bsel_n = 4'h0;
      end
      @(posedge clk);
      if (en) begin
         if (cur_vld && cur_wr) begin
            for (int i = 0; i < 4; i++)
               if (!pd_mask[i]) emem[cur_addr][i*9 +: 9] = pd_data[i*9 +: 9];
         end
         if (ld) begin
            cur_vld = csok && !slp;
            cur_wr = w;
            cur_addr = AW'(a);
            base = 2'(a);
            cnt = 2'd0;
         end else begin
            cur_vld = cur_vld && !slp;
            cnt = cnt + 2'd1;
            cur_addr[1:0] = burst_ilv ? (base ^ cnt) : (base + cnt);
         end
         pd_data = wd;
         pd_mask = bm;
      end
      #1;
      chk(dq_oe == (cur_vld && !cur_wr && !oe_n), {tag, " dq_oe"},
          36'(dq_oe), 36'(cur_vld && !cur_wr && !oe_n));
      if (cur_vld && !cur_wr)
         chk(dq_out == emem[cur_addr], {tag, " dq_out"}, dq_out, emem[cur_addr]);
   endtask

   initial begin
      for (int i = 0; i < DEPTH; i++) emem[i] = '0;
      // R10: reset state
      repeat (3) @(posedge clk);
      #1;
      chk(dq_oe == 1'b0, "R10 reset dq_oe", 36'(dq_oe), 36'h0);
      rst_n = 1'b1;

      // R2: full-word fill of every address, back to back (then R1 read sweep)
      for (int a = 0; a < DEPTH; a++)
         op(1, 1, a, pat(a), 4'h0, 3'b010, 0, 1, "R2 fill");
      for (int a = 0; a < DEPTH; a++)
         op(1, 0, a, '0, 4'hF, 3'b010, 0, 1, "R1 read");

      // R2/R3: masked writes, each followed at once by a read of the same word
      for (int a = 0; a < 16; a++) begin
         op(1, 1, a, ~pat(a), 4'(a), 3'b010, 0, 1, "R2 masked write");
         op(1, 0, a, '0, 4'hF, 3'b010, 0, 1, "R3 read after write");
      end
      // R3: read then write then read of different words, alternating
      for (int a = 16; a < 24; a++) begin
         op(1, 0, a + 8, '0, 4'hF, 3'b010, 0, 1, "R3 read");
         op(1, 1, a, pat(a + 100), 4'h0, 3'b010, 0, 1, "R3 write after read");
      end
      op(1, 0, 16, '0, 4'hF, 3'b010, 0, 1, "R3 read");

      // R4: every chip-select combination attempts a write to word 5
      for (int c = 0; c < 8; c++) begin
         op(1, 1, 5, 36'h1_2345_6780 + 36'(c), 4'h0, 3'(c), 0, 1, "R4 select write");
         op(1, 0, 5, '0, 4'hF, 3'b010, 0, 1, "R4 select readback");
      end

      // R5: oe_n gating, combinational and during read
      op(1, 0, 7, '0, 4'hF, 3'b010, 0, 1, "R5 read");
      oe_n = 1'b1;
      #1;
      chk(dq_oe == 1'b0, "R5 oe_n high", 36'(dq_oe), 36'h0);
      oe_n = 1'b0;
      #1;
      chk(dq_oe == 1'b1, "R5 oe_n low", 36'(dq_oe), 36'h1);
      oe_n = 1'b1;
      op(1, 0, 8, '0, 4'hF, 3'b010, 0, 1, "R5 read oe_n high");
      oe_n = 1'b0;
      op(1, 1, 9, pat(9) ^ 36'hF_0000_000F, 4'h0, 3'b010, 0, 1, "R5 write data cycle");

      // R6: stalls during a read and across a pending write
      op(1, 0, 7, '0, 4'hF, 3'b010, 0, 1, "R6 read before stall");
      for (int s = 0; s < 3; s++)
         op(1, 1, 30, 36'h0, 4'h0, 3'b010, 0, 0, "R6 stall read hold");
      op(1, 1, 11, 36'hA_BCDE_F012, 4'h0, 3'b010, 0, 1, "R6 write before stall");
      for (int s = 0; s < 2; s++)
         op(1, 0, 12, '0, 4'hF, 3'b010, 0, 0, "R6 stall write pending");
      op(1, 0, 11, '0, 4'hF, 3'b010, 0, 1, "R6 read after stall");

      // R7 (linear) and R8 (interleaved): write burst then read burst with wrap
      for (int m = 0; m < 2; m++) begin
         burst_ilv = m[0];
         for (int b = 0; b < 4; b++) begin
            int g;
            g = 32 + 8 * m + 4 * (b % 2) + b;
            op(1, 1, g, 36'h5_0000_0000 + 36'(m * 16 + b * 4), 4'h0, 3'b010, 0, 1,
               m == 0 ? "R7 burst write" : "R8 burst write");
            for (int k = 1; k < 4; k++)
               op(0, 0, 0, 36'h5_0000_0000 + 36'(m * 16 + b * 4 + k), 4'h0, 3'b101, 0, 1,
                  m == 0 ? "R7 burst write beat" : "R8 burst write beat");
            op(1, 0, g, '0, 4'hF, 3'b010, 0, 1, m == 0 ? "R7 burst read" : "R8 burst read");
            for (int k = 1; k < 5; k++)
               op(0, 1, 0, '0, 4'hF, 3'b111, 0, 1,
                  m == 0 ? "R7 burst read beat" : "R8 burst read beat");
         end
      end
      burst_ilv = 1'b0;

      // R9: sleep blocks loads and ends bursts
      op(1, 0, 3, '0, 4'hF, 3'b010, 1, 1, "R9 sleep read");
      op(1, 1, 3, 36'h0, 4'h0, 3'b010, 1, 1, "R9 sleep write");
      op(1, 0, 3, '0, 4'hF, 3'b010, 0, 1, "R9 readback");
      op(0, 0, 0, '0, 4'hF, 3'b111, 1, 1, "R9 sleep in burst");
      // R11: continuing after a deselect stays idle
      op(0, 0, 0, '0, 4'hF, 3'b111, 0, 1, "R11 continue idle");
      op(1, 1, 4, 36'h0, 4'h0, 3'b000, 0, 1, "R11 deselect");
      op(0, 0, 0, 36'h0, 4'h0, 3'b010, 0, 1, "R11 continue idle");
      op(1, 0, 4, '0, 4'hF, 3'b010, 0, 1, "R11 readback");
      op(1, 0, 0, '0, 4'hF, 3'b000, 0, 1, "R4 idle");

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule